// File: doc/BRIEF.md
# Saturating Counting Semaphore Cell

This block holds one 16-bit counting semaphore that many requesters share. A read is a P operation and a write is a V operation. A read returns the count and takes one unit when the count is positive. A write adds one unit. Its data is discarded, and the count stops at the all-ones value instead of wrapping.

Each read names one of two P forms. The waiting form parks the requester when the count is zero: the requester's bit is set in a mask of waiters, and the response is flagged as suspended. The try form never parks; at zero it returns zero and changes nothing. Any V operation wakes every parked requester with a single one-cycle pulse that carries the mask, and then clears the mask. A woken requester issues its read again and may be parked again if another requester has already taken the unit.

A third access form, the raw view, lets software inspect the count without changing it. Writes through this view are dropped.

Top module: `semaphoreCell`

## Requirements
- R1: While and after reset, the count is zero, no requester is waiting, and respValid and wakeValid are low.
- R2: A read in view 0 (wait) or view 1 (try) with a count above zero responds one cycle after acceptance with respData equal to the count before the access and respSuspend low. The count then drops by one.
- R3: A read in view 0 (wait) with a zero count responds one cycle later with respSuspend high and respData zero. It sets bit reqId of the waiter mask and leaves the count at zero.
- R4: A read in view 1 (try) with a zero count responds with respData zero and respSuspend low. It changes neither the count nor the waiter mask.
- R5: A write in view 0 or view 1 ignores reqData and raises the count by one. It produces no response.
- R6: A write when the count is 0xFFFF leaves the count at 0xFFFF.
- R7: A write in view 0 or 1 while the waiter mask is non-zero raises wakeValid for exactly one cycle, the cycle after acceptance. In that cycle wakeMask carries the mask as it was before the write, and the mask is cleared. With no waiters there is no pulse.
- R8: In views 2 and 3 (raw), a write changes nothing. A read returns the count with respSuspend low and leaves all state unchanged.
- R9: A requester that was woken and reads in view 0 after another requester has taken the count to zero is parked again and appears in the next wake mask.
- R10: reqReady is high whenever reset is low, so every valid request is accepted in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle |
| reqWrite | input | 1 | 1 = write (V), 0 = read (P) |
| reqView | input | 2 | 0 = wait P/V, 1 = try P/V, 2 or 3 = raw |
| reqId | input | ID_W (3) | Requester number |
| reqData | input | CNT_W (16) | Write data, discarded |
| respValid | output | 1 | Read response present |
| respData | output | CNT_W (16) | Count returned by a read |
| respSuspend | output | 1 | Requester was parked |
| wakeValid | output | 1 | One-cycle wake pulse |
| wakeMask | output | NUM_REQ (8) | Requesters woken by the pulse |

## Verification
Some properties are checked by assertions on every cycle. These are:
- the count moves by at most one per cycle and never wraps from the top;
- the P and V strobes are mutually exclusive;
- a wake pulse carries a non-empty mask, clears the waiters, and never lasts two cycles;
- a suspended response always has zero data;
- the block is ready whenever reset is low.

Other behaviour can only be shown by the bench's scenarios, where a reference model follows the semaphore cycle by cycle. These cover:
- the exact values returned;
- which requester bits build up in the mask before a wake;
- the second parking of a retried requester;
- that writes with data and writes in the raw view are ignored;
- saturation after a long run of V writes.

// File: rtl/semaphore_pkg.sv
package semaphore_pkg;

  typedef enum logic [1:0] {
    VIEW_PV_WAIT = 2'd0,
    VIEW_PV_TRY  = 2'd1,
    VIEW_RAW     = 2'd2,
    VIEW_RAW_ALT = 2'd3
  } semView_e;

  typedef struct packed {
    logic takeP;
    logic giveV;
    logic parkReq;
    logic wakeAll;
    logic respond;
  } semStrobe_t;

endpackage

// File: rtl/semCtrl.sv
module semCtrl
  import semaphore_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             rst,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [1:0]       reqView,
  input  logic [CNT_W-1:0] reqData,
  input  logic             countZero,
  input  logic             countMax,
  input  logic             anyWaiting,
  output logic             reqReady,
  output semStrobe_t       strobe
);

  semView_e view;
  logic accept;
  logic pvView;

  always_comb begin
    view     = semView_e'(reqView);
    reqReady = !rst;
    accept   = reqValid && reqReady;
    pvView   = (view == VIEW_PV_WAIT) || (view == VIEW_PV_TRY);

    strobe.respond = accept && !reqWrite;
    strobe.takeP   = accept && !reqWrite && pvView && !countZero;
    strobe.parkReq = accept && !reqWrite && (view == VIEW_PV_WAIT) && countZero;
    strobe.giveV   = accept && reqWrite && pvView && !countMax;
    strobe.wakeAll = accept && reqWrite && pvView && anyWaiting;
  end

  // R10
  always_comb begin
    if (!rst) begin
      ready_out_chk: assert (reqReady);
    end
  end

  // R5: the discarded write data is still expected to be driven
  always_comb begin
    if (!rst && reqValid && reqWrite) begin
      wdata_known_chk: assert (!$isunknown(reqData));
    end
  end

  // R2 R3 R5
  always_comb begin
    if (!rst) begin
      strobe_excl_chk: assert ($onehot0({strobe.takeP, strobe.giveV, strobe.parkReq}));
    end
  end

endmodule

// File: rtl/semDatapath.sv
module semDatapath
  import semaphore_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_REQ = 8,
  localparam int ID_W   = $clog2(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  semStrobe_t         strobe,
  input  logic [ID_W-1:0]    reqId,
  output logic               countZero,
  output logic               countMax,
  output logic               anyWaiting,
  output logic               respValid,
  output logic [CNT_W-1:0]   respData,
  output logic               respSuspend,
  output logic               wakeValid,
  output logic [NUM_REQ-1:0] wakeMask
);

  localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};

  logic [CNT_W-1:0]   count;
  logic [NUM_REQ-1:0] waiters;

  assign countZero  = (count == '0);
  assign countMax   = (count == MAX_CNT);
  assign anyWaiting = |waiters;

  always_ff @(posedge clk) begin
    if (rst) begin
      count       <= '0;
      waiters     <= '0;
      respValid   <= 1'b0;
      respData    <= '0;
      respSuspend <= 1'b0;
      wakeValid   <= 1'b0;
      wakeMask    <= '0;
    end else begin
      respValid   <= strobe.respond;
      respSuspend <= strobe.parkReq;
      respData    <= (strobe.respond && !strobe.parkReq) ? count : '0;
      if (strobe.takeP) begin
        count <= count - 1'b1;
      end else if (strobe.giveV) begin
        count <= count + 1'b1;
      end
      wakeValid <= strobe.wakeAll;
      wakeMask  <= strobe.wakeAll ? waiters : '0;
      if (strobe.wakeAll) begin
        waiters <= '0;
      end else if (strobe.parkReq) begin
        waiters[reqId] <= 1'b1;
      end
    end
  end

  // R2 R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(count) |-> ((count == $past(count) + 1'b1) || (count == $past(count) - 1'b1)));

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(count) == MAX_CNT) |-> (count >= MAX_CNT - 1'b1));

  // R7
  wake_mask_chk: assert property (@(posedge clk) disable iff (rst)
    wakeValid |-> ((wakeMask != '0) && (waiters == '0)));

  // R7
  wake_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wakeValid |=> !wakeValid);

  // R3
  park_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (respValid && respSuspend) |-> ((respData == '0) && (waiters != '0)));

endmodule

// File: rtl/semaphoreCell.sv
module semaphoreCell
  import semaphore_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_REQ = 8,
  localparam int ID_W   = $clog2(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWrite,
  input  logic [1:0]         reqView,
  input  logic [ID_W-1:0]    reqId,
  input  logic [CNT_W-1:0]   reqData,
  output logic               respValid,
  output logic [CNT_W-1:0]   respData,
  output logic               respSuspend,
  output logic               wakeValid,
  output logic [NUM_REQ-1:0] wakeMask
);

  semStrobe_t strobe;
  logic countZero;
  logic countMax;
  logic anyWaiting;

  semCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .rst        (rst),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqView    (reqView),
    .reqData    (reqData),
    .countZero  (countZero),
    .countMax   (countMax),
    .anyWaiting (anyWaiting),
    .reqReady   (reqReady),
    .strobe     (strobe)
  );

  semDatapath #(.CNT_W(CNT_W), .NUM_REQ(NUM_REQ)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .reqId       (reqId),
    .countZero   (countZero),
    .countMax    (countMax),
    .anyWaiting  (anyWaiting),
    .respValid   (respValid),
    .respData    (respData),
    .respSuspend (respSuspend),
    .wakeValid   (wakeValid),
    .wakeMask    (wakeMask)
  );

endmodule

// File: tb/semaphoreCell_tb.sv
module semaphoreCell_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int NUM_REQ    = 8;
  localparam int ID_W       = $clog2(NUM_REQ);
  localparam int MAXV       = 65535;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic reqReady;
  logic reqWrite = 1'b0;
  logic [1:0] reqView = 2'd0;
  logic [ID_W-1:0] reqId = '0;
  logic [CNT_W-1:0] reqData = '0;
  logic respValid;
  logic [CNT_W-1:0] respData;
  logic respSuspend;
  logic wakeValid;
  logic [NUM_REQ-1:0] wakeMask;

  always #(CLK_PERIOD/2) clk = ~clk;

  semaphoreCell #(.CNT_W(CNT_W), .NUM_REQ(NUM_REQ)) u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqView(reqView), .reqId(reqId), .reqData(reqData),
    .respValid(respValid), .respData(respData), .respSuspend(respSuspend),
    .wakeValid(wakeValid), .wakeMask(wakeMask)
  );

  // behavioural reference model
  int refCount = 0;
  int refWaiters = 0;
  int eRespValid = 0, eRespData = 0, eSusp = 0, eWake = 0, eMask = 0;
  int compared = 0, mismatched = 0, cycles = 0;
  string phase = "R1";

  always @(posedge clk) begin
    cycles++;
    eRespValid = 0; eRespData = 0; eSusp = 0; eWake = 0; eMask = 0;
    if (rst) begin
      refCount = 0; refWaiters = 0;
    end else if (reqValid) begin
      if (!reqWrite) begin
        eRespValid = 1;
        if (reqView >= 2) begin
          eRespData = refCount;
        end else if (refCount > 0) begin
          eRespData = refCount;
          refCount--;
        end else if (reqView == 0) begin
          eSusp = 1;
          refWaiters |= (1 << reqId);
        end
      end else if (reqView < 2) begin
        if (refWaiters != 0) begin
          eWake = 1; eMask = refWaiters; refWaiters = 0;
        end
        if (refCount < MAXV) refCount++;
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", phase, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cmp("reqReady (R10)", int'(reqReady), rst ? 0 : 1);
    cmp("respValid", int'(respValid), eRespValid);
    cmp("respData", int'(respData), eRespData);
    cmp("respSuspend", int'(respSuspend), eSusp);
    cmp("wakeValid", int'(wakeValid), eWake);
    cmp("wakeMask", int'(wakeMask), eMask);
  end

  task automatic op(input logic wr, input logic [1:0] v, input int id, input int data);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqView = v;
    reqId = ID_W'(id); reqData = CNT_W'(data);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    phase = "R1"; idle(3);
    phase = "R4"; op(1'b0, 2'd1, 1, 0); idle(1);
    phase = "R3"; op(1'b0, 2'd0, 2, 0); op(1'b0, 2'd0, 5, 0); idle(1);
    phase = "R8"; op(1'b1, 2'd2, 0, 123); op(1'b1, 2'd3, 0, 7); op(1'b0, 2'd2, 0, 0); idle(1);
    phase = "R5"; op(1'b1, 2'd0, 0, 16'hdead); idle(1);
    phase = "R9"; op(1'b0, 2'd0, 3, 0); op(1'b0, 2'd0, 2, 0); idle(1);
    phase = "R7"; op(1'b1, 2'd1, 0, 0); op(1'b1, 2'd0, 0, 0); idle(2);
    phase = "R2"; op(1'b0, 2'd1, 4, 0); op(1'b0, 2'd0, 6, 0); op(1'b0, 2'd1, 4, 0); idle(1);
    phase = "R6";
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqView = 2'd1; reqData = 16'h5a5a;
    for (int i = 0; i < MAXV + 4; i++) @(negedge clk);
    reqValid = 1'b0;
    op(1'b0, 2'd2, 0, 0); op(1'b0, 2'd0, 1, 0); op(1'b1, 2'd0, 0, 0); op(1'b1, 2'd0, 0, 0);
    op(1'b0, 2'd1, 0, 0); idle(1);
    phase = "mixed R2 R3 R4 R5 R7 R8";
    rst = 1'b1; idle(2); rst = 1'b0; phase = "R1 mixed"; idle(1);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      reqValid = ($urandom_range(0, 3) != 0);
      reqWrite = ($urandom_range(0, 2) == 0);
      reqView  = 2'($urandom_range(0, 3));
      reqId    = ID_W'($urandom_range(0, NUM_REQ-1));
      reqData  = CNT_W'($urandom);
    end
    @(negedge clk); reqValid = 1'b0;
    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    compared++; mismatched++;
    $display("FAIL watchdog %s: actual timeout expected completion", phase);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule